// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital control half of a successive-approximation converter. It closes a sample switch, drives a trial code into the converter's internal DAC and reads back a single comparator bit. From those three signals it performs one binary search per conversion, fixing one bit per clock from the most significant bit down to the least significant bit.

A single start pulse launches a scan over a short programmable list of multiplexed input channels. The list, its length and the sample time are all captured at the moment the pulse is accepted.

Two analog hazards are handled in logic:
- **Charge left from the previous channel.** After every change of mux channel, an extra conversion runs on the new channel first. Its result is thrown away.
- **Reference startup.** No scan can begin until a startup counter has covered the reference settling time after reset.

Results leave on a plain one-clock strobe, tagged with the channel that was converted. The result port has no back-pressure, because the analog timing cannot be stalled, so the consumer must capture the result in the strobe cycle.

Top module: `sar_scan_seq`

## Requirements
- R1: After reset, a trigger that arrives before REF_WAIT (default 32) clocks have elapsed is ignored. It produces no sample phase and no result, and it does not set the overrun flag.
- R2: Every bit search is preceded by a sample phase. In that phase `sh_close_o` is high for exactly the captured sample time in consecutive clocks, and a value of 0 is treated as 1. `sh_close_o` is low and `mux_sel_o` is stable while trial codes are driven.
- R3: A conversion drives exactly RES_BITS (default 12) nonzero trial codes, one per clock. The first trial code is the MSB alone. Each trial code is the bits already decided OR the current bit. That bit is kept when `cmp_i` is 1 (input at or above the trial level) and cleared otherwise. The reported result equals the held input level.
- R4: An accepted trigger converts list entries 0 to `list_len_i` in order. Entry k occupies bits [k*CH_W +: CH_W] of `chan_list_i`, and `list_len_i` holds the entry count minus one.
- R5: A conversion whose channel differs from the channel of the previously launched conversion is preceded by one extra conversion of the same channel whose result is not reported. The first conversion after reset always counts as a channel change.
- R6: Consecutive conversions on the same channel, including the last conversion of one scan and the first of the next, get no extra conversion.
- R7: `res_valid_o` is high for one clock per reported result. In that clock, `res_data_o` holds the code and `res_chan_o` holds the converted channel.
- R8: A trigger that arrives while a scan is in progress is ignored and sets `overrun_o`, which stays high until reset.
- R9: The channel list, list length and sample time are captured when the trigger is accepted. Changes to those inputs during a scan do not affect that scan.
- R10: During and right after reset, `sh_close_o`, `dac_code_o`, `res_valid_o` and `overrun_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Scan start pulse (e.g. from a periodic timer) |
| list_len_i | input | IDX_W | Number of list entries minus one |
| chan_list_i | input | LIST_DEPTH*CH_W | Packed channel list, entry 0 in the low bits |
| smp_clks_i | input | SMP_W | Sample phase length in clocks |
| cmp_i | input | 1 | Comparator: 1 when held input is at or above trial level |
| mux_sel_o | output | CH_W | Input mux channel select |
| dac_code_o | output | RES_BITS | Trial code to the converter DAC |
| sh_close_o | output | 1 | Sample switch closed |
| res_data_o | output | RES_BITS | Conversion result |
| res_chan_o | output | CH_W | Channel tag of the result |
| res_valid_o | output | 1 | One-clock result strobe |
| overrun_o | output | 1 | Sticky flag: trigger arrived during a scan |

## Verification
The hardest condition to reach from the ports is a conversion whose result would be wrong without the extra conversion. The digital side alone never shows the charge carried over from the previous channel. The bench therefore models the hold capacitor: on the first sample phase after a channel change it holds the average of the old and new levels, and a following sample of the same channel holds the true level. A missing or misplaced extra conversion then surfaces as a wrong result code.

Scans are arranged so that the channel changes inside one list, repeats within a list, and repeats across two scans. Triggers are placed before the reference is ready and in the middle of a running scan.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_CONVERT
  } seq_state_e;
endpackage

// File: rtl/sar_ref_gate.sv
// Counts the reference settling time after reset and then reports ready.
module sar_ref_gate #(
  parameter int WAIT_CLKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready_o
);
  localparam int CW = $clog2(WAIT_CLKS + 2);
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_CLKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ready_o = (cnt == LIMIT);
endmodule

// File: rtl/sar_sample_timer.sv
// Holds the sample switch closed for a loaded number of clocks (minimum one).
module sar_sample_timer #(
  parameter int SMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SMP_W-1:0] len_i,
  output logic             sh_o,
  output logic             last_o
);
  logic [SMP_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start_i) begin
      cnt <= (len_i == '0) ? SMP_W'(1) : len_i;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign sh_o   = (cnt != '0);
  assign last_o = (cnt == SMP_W'(1));
endmodule

// File: rtl/sar_bit_search.sv
// Binary search engine: one decided bit per clock, MSB first.
module sar_bit_search #(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] trial_o,
  output logic                done_o,
  output logic [RES_BITS-1:0] result_o
);
  localparam logic [RES_BITS-1:0] TOP_BIT = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] acc;
  logic [RES_BITS-1:0] mask;
  logic                active;

  assign active = |mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      mask   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        acc  <= '0;
        mask <= TOP_BIT;
      end else if (active) begin
        if (cmp_i) begin
          acc <= acc | mask;
        end
        mask <= mask >> 1;
        if (mask[0]) begin
          done_o <= 1'b1;
        end
      end
    end
  end

  assign trial_o  = active ? (acc | mask) : '0;
  assign result_o = acc;
endmodule

// File: rtl/sar_scan_seq.sv
module sar_scan_seq #(
  parameter int RES_BITS   = 12,
  parameter int CH_W       = 3,
  parameter int LIST_DEPTH = 4,
  parameter int SMP_W      = 8,
  parameter int REF_WAIT   = 32,
  localparam int IDX_W     = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       trig_i,
  input  logic [IDX_W-1:0]           list_len_i,
  input  logic [LIST_DEPTH*CH_W-1:0] chan_list_i,
  input  logic [SMP_W-1:0]           smp_clks_i,
  input  logic                       cmp_i,
  output logic [CH_W-1:0]            mux_sel_o,
  output logic [RES_BITS-1:0]        dac_code_o,
  output logic                       sh_close_o,
  output logic [RES_BITS-1:0]        res_data_o,
  output logic [CH_W-1:0]            res_chan_o,
  output logic                       res_valid_o,
  output logic                       overrun_o
);
  import sar_seq_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LIST_DEPTH - 1);

  seq_state_e                 state;
  logic [LIST_DEPTH*CH_W-1:0] list_q;
  logic [IDX_W-1:0]           len_q;
  logic [IDX_W-1:0]           idx;
  logic [SMP_W-1:0]           smp_q;
  logic [CH_W-1:0]            cur_chan;
  logic [CH_W-1:0]            last_chan;
  logic                       last_vld;
  logic                       dummy;

  logic                       ref_ready;
  logic                       accept;
  logic                       tmr_start;
  logic [SMP_W-1:0]           tmr_len;
  logic                       tmr_last;
  logic                       srch_start;
  logic                       srch_done;
  logic [RES_BITS-1:0]        srch_result;
  logic [IDX_W-1:0]           next_idx;
  logic [CH_W-1:0]            next_chan;
  logic [CH_W-1:0]            first_chan;
  logic [IDX_W-1:0]           len_clamp;
  logic [CH_W-1:0]            list_arr [LIST_DEPTH];

  // Unpack the captured list into addressable entries
  for (genvar k = 0; k < LIST_DEPTH; k++) begin : g_unpack
    assign list_arr[k] = list_q[k*CH_W +: CH_W];
  end

  sar_ref_gate #(.WAIT_CLKS(REF_WAIT)) u_ref (
    .clk    (clk),
    .rst_n  (rst_n),
    .ready_o(ref_ready)
  );

  sar_sample_timer #(.SMP_W(SMP_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(tmr_start),
    .len_i  (tmr_len),
    .sh_o   (sh_close_o),
    .last_o (tmr_last)
  );

  sar_bit_search #(.RES_BITS(RES_BITS)) u_srch (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (srch_start),
    .cmp_i   (cmp_i),
    .trial_o (dac_code_o),
    .done_o  (srch_done),
    .result_o(srch_result)
  );

  assign first_chan = chan_list_i[CH_W-1:0];
  assign len_clamp  = (list_len_i > LAST_IDX) ? LAST_IDX : list_len_i;
  assign next_idx   = idx + 1'b1;
  assign next_chan  = list_arr[next_idx];
  assign accept     = trig_i && ref_ready && (state == ST_IDLE);
  assign srch_start = (state == ST_SAMPLE) && tmr_last;
  assign tmr_start  = accept ||
                      ((state == ST_CONVERT) && srch_done && (dummy || (idx != len_q)));
  assign tmr_len    = accept ? smp_clks_i : smp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      list_q      <= '0;
      len_q       <= '0;
      idx         <= '0;
      smp_q       <= '0;
      cur_chan    <= '0;
      last_chan   <= '0;
      last_vld    <= 1'b0;
      dummy       <= 1'b0;
      res_data_o  <= '0;
      res_chan_o  <= '0;
      res_valid_o <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      res_valid_o <= 1'b0;
      if (trig_i && (state != ST_IDLE)) begin
        overrun_o <= 1'b1;
      end
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            list_q    <= chan_list_i;
            len_q     <= len_clamp;
            smp_q     <= smp_clks_i;
            idx       <= '0;
            cur_chan  <= first_chan;
            dummy     <= !last_vld || (first_chan != last_chan);
            last_chan <= first_chan;
            last_vld  <= 1'b1;
            state     <= ST_SAMPLE;
          end
        end
        ST_SAMPLE: begin
          if (tmr_last) begin
            state <= ST_CONVERT;
          end
        end
        ST_CONVERT: begin
          if (srch_done) begin
            if (dummy) begin
              // discard: convert the same channel once more
              dummy <= 1'b0;
              state <= ST_SAMPLE;
            end else begin
              res_valid_o <= 1'b1;
              res_data_o  <= srch_result;
              res_chan_o  <= cur_chan;
              if (idx == len_q) begin
                state <= ST_IDLE;
              end else begin
                idx       <= next_idx;
                cur_chan  <= next_chan;
                dummy     <= (next_chan != cur_chan);
                last_chan <= next_chan;
                state     <= ST_SAMPLE;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mux_sel_o = cur_chan;
endmodule

// File: rtl/sar_scan_seq_chk.sv
module sar_scan_seq_chk #(
  parameter int RES_BITS = 12,
  parameter int CH_W     = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ref_ready,
  input logic                sh_close_o,
  input logic [RES_BITS-1:0] dac_code_o,
  input logic [CH_W-1:0]     mux_sel_o,
  input logic                res_valid_o,
  input logic                overrun_o
);
  localparam logic [RES_BITS-1:0] TOP_BIT = {1'b1, {(RES_BITS-1){1'b0}}};

  AST_NO_SAMPLE_BEFORE_REF: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ready |-> !sh_close_o); // R1

  AST_SWITCH_OPEN_IN_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code_o != '0) |-> !sh_close_o); // R2

  AST_MUX_STEADY_IN_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code_o != '0) |-> $stable(mux_sel_o)); // R2

  AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_code_o != '0) |-> (dac_code_o == TOP_BIT)); // R3

  AST_VALID_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o); // R7

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o); // R8
endmodule

bind sar_scan_seq sar_scan_seq_chk #(.RES_BITS(RES_BITS), .CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_ready  (ref_ready),
  .sh_close_o (sh_close_o),
  .dac_code_o (dac_code_o),
  .mux_sel_o  (mux_sel_o),
  .res_valid_o(res_valid_o),
  .overrun_o  (overrun_o)
);

// File: tb/tb_sar_scan_seq.sv
`timescale 1ns/1ps
module tb_sar_scan_seq;
  localparam int RB = 12;
  localparam int CW = 3;
  localparam int LD = 4;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig = 1'b0;
  logic [1:0]    list_len = '0;
  logic [LD*CW-1:0] chan_list = '0;
  logic [SW-1:0] smp_clks = '0;
  logic          cmp;
  logic [CW-1:0] mux_sel;
  logic [RB-1:0] dac_code;
  logic          sh_close;
  logic [RB-1:0] res_data;
  logic [CW-1:0] res_chan;
  logic          res_valid;
  logic          overrun;

  always #5 clk = ~clk;

  sar_scan_seq dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .list_len_i(list_len),
    .chan_list_i(chan_list), .smp_clks_i(smp_clks), .cmp_i(cmp),
    .mux_sel_o(mux_sel), .dac_code_o(dac_code), .sh_close_o(sh_close),
    .res_data_o(res_data), .res_chan_o(res_chan), .res_valid_o(res_valid),
    .overrun_o(overrun)
  );

  int n_chk = 0;
  int n_fail = 0;
  int vin [8] = '{100, 4095, 2000, 0, 3333, 1234, 777, 2890};
  int held = 0;
  int model_chan = 99;
  int exp_smp = 1;
  int n_phase = 0;
  int n_valid = 0;
  int sh_w = 0;
  int trial_cnt = 0;
  bit sh_prev = 0;
  bit valid_prev = 0;
  int got_chan [16];
  int got_data [16];

  // Comparator: held level against the trial code
  assign cmp = (held >= int'(dac_code));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Analog front end model and protocol monitors
  always @(negedge clk) begin
    if (rst_n) begin
      if (sh_close && !sh_prev) begin
        n_phase++;
        if (int'(mux_sel) == model_chan) held = vin[mux_sel];
        else held = (held + vin[mux_sel]) / 2;
        model_chan = int'(mux_sel);
        sh_w = 0;
      end
      if (sh_close) sh_w++;
      if (!sh_close && sh_prev) begin
        chk(sh_w == exp_smp, "R2 sample phase length", sh_w, exp_smp);
        trial_cnt = 0;
      end
      if (dac_code != '0) begin
        if (trial_cnt == 0) chk(dac_code == 12'h800, "R3 first trial code", int'(dac_code), 2048);
        trial_cnt++;
      end
      if (res_valid) begin
        chk(trial_cnt == RB, "R3 trial count", trial_cnt, RB);
        chk(!valid_prev, "R7 strobe one clock wide", int'(valid_prev), 0);
        if (n_valid < 16) begin
          got_chan[n_valid] = int'(res_chan);
          got_data[n_valid] = int'(res_data);
        end
        n_valid++;
      end
      sh_prev = sh_close;
      valid_prev = res_valid;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic pulse_trig();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  task automatic wait_valids(input int n);
    int guard = 0;
    while (n_valid < n && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic setup(input int c0, input int c1, input int c2, input int c3,
                       input int len, input int smp);
    chan_list = {CW'(c3), CW'(c2), CW'(c1), CW'(c0)};
    list_len  = 2'(len);
    smp_clks  = SW'(smp);
    exp_smp   = (smp == 0) ? 1 : smp;
    n_phase   = 0;
    n_valid   = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sh_close == 1'b0, "R10 sh_close in reset", int'(sh_close), 0);
    chk(dac_code == '0, "R10 dac_code in reset", int'(dac_code), 0);
    chk(res_valid == 1'b0, "R10 valid in reset", int'(res_valid), 0);
    chk(overrun == 1'b0, "R10 overrun in reset", int'(overrun), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_ref_gate();
    setup(2, 2, 2, 2, 0, 3);
    repeat (2) @(negedge clk);
    pulse_trig();
    repeat (40) @(negedge clk);
    chk(n_phase == 0, "R1 no sample before reference ready", n_phase, 0);
    chk(n_valid == 0, "R1 no result before reference ready", n_valid, 0);
    chk(overrun == 1'b0, "R1 early trigger sets no overrun", int'(overrun), 0);
  endtask

  task automatic t_scan();
    setup(2, 5, 5, 1, 3, 4);
    pulse_trig();
    wait_valids(4);
    chk(n_valid == 4, "R4 result count", n_valid, 4);
    chk(got_chan[0] == 2, "R4 entry0 tag", got_chan[0], 2);
    chk(got_chan[1] == 5, "R4 entry1 tag", got_chan[1], 5);
    chk(got_chan[2] == 5, "R4 entry2 tag", got_chan[2], 5);
    chk(got_chan[3] == 1, "R7 entry3 tag", got_chan[3], 1);
    chk(got_data[0] == 2000, "R5 data after switch ch2", got_data[0], 2000);
    chk(got_data[1] == 1234, "R5 data after switch ch5", got_data[1], 1234);
    chk(got_data[2] == 1234, "R6 repeat ch5 data", got_data[2], 1234);
    chk(got_data[3] == 4095, "R3 full scale code", got_data[3], 4095);
    chk(n_phase == 7, "R5 extra conversions on switches", n_phase, 7);
  endtask

  task automatic t_same_chan();
    setup(3, 0, 0, 0, 0, 0);
    pulse_trig();
    wait_valids(1);
    chk(n_phase == 2, "R5 switch to ch3 adds one conversion", n_phase, 2);
    chk(got_data[0] == 0, "R3 zero code", got_data[0], 0);
    setup(3, 0, 0, 0, 0, 0);
    pulse_trig();
    wait_valids(1);
    chk(n_phase == 1, "R6 same channel across scans", n_phase, 1);
    chk(got_chan[0] == 3 && got_data[0] == 0, "R6 repeat scan result", got_data[0], 0);
  endtask

  task automatic t_snapshot();
    setup(6, 0, 0, 0, 1, 3);
    pulse_trig();
    repeat (3) @(negedge clk);
    chan_list = {LD{CW'(7)}};
    list_len  = 2'd3;
    smp_clks  = SW'(9);
    wait_valids(2);
    repeat (60) @(negedge clk);
    chk(n_valid == 2, "R9 length from capture", n_valid, 2);
    chk(got_chan[0] == 6, "R9 tag 0 from capture", got_chan[0], 6);
    chk(got_chan[1] == 0, "R9 tag 1 from capture", got_chan[1], 0);
    chk(got_data[0] == 777, "R9 data 0", got_data[0], 777);
    chk(got_data[1] == 100, "R9 data 1", got_data[1], 100);
    chk(n_phase == 4, "R5 phases in snapshot scan", n_phase, 4);
  endtask

  task automatic t_overrun();
    setup(0, 0, 0, 0, 0, 5);
    chk(overrun == 1'b0, "R8 overrun clear before", int'(overrun), 0);
    pulse_trig();
    repeat (6) @(negedge clk);
    pulse_trig();
    wait_valids(1);
    repeat (60) @(negedge clk);
    chk(n_valid == 1, "R8 mid-scan trigger ignored", n_valid, 1);
    chk(n_phase == 1, "R6 no extra conversion on same channel", n_phase, 1);
    chk(got_data[0] == 100, "R8 result unaffected", got_data[0], 100);
    chk(overrun == 1'b1, "R8 overrun set and held", int'(overrun), 1);
  endtask

  initial begin
    t_reset();
    t_ref_gate();
    t_scan();
    t_same_chan();
    t_snapshot();
    t_overrun();
    finish_run();
  end
endmodule